// File: doc/BRIEF.md
# Port flush table sweeper

This block walks an external forwarding table once per flush command and removes or trims the entries tied to a given set of switch ports. A command carries a port mask and a mode bit. The block reads every index in ascending order and evaluates each address entry. It then writes the entry back to the same index, freed, trimmed or unchanged. Free and VLAN-only entries are passed over and never written.

Two sweeps are offered. A full flush frees unicast entries learned on a flushed port and trims multicast port sets. A multicast-only flush leaves unicast entries and the broadcast entry alone and trims only multicast port sets. A multicast entry is freed once nothing but the host port (port 0) would remain.

Top module: `ptfl_sweeper`

Each table entry is ENTRY_W bits, packed from the top down as: type (2 bits; 0 free, 1 address, 2 VLAN, 3 VLAN+address), multicast flag (1), MAC address (48), VLAN id (12), port mask (PORTS bits, bit p = port p), port number (PN_W bits, used by unicast entries).

## Requirements
- R1: After reset, busy, done, the table read enable and the table write enable are all 0.
- R2: An accepted command raises busy in the next cycle for exactly 2*DEPTH cycles. done is 1 for the single cycle in which busy has just fallen.
- R3: Indexes are read once each, from 0 up to DEPTH-1 in order. Any write lands one cycle after the read of the same index.
- R4: Entries of type 0 (free) or 2 (VLAN) are never written.
- R5: A multicast entry whose port mask shares no bit with the flush mask is written back unchanged.
- R6: An overlapping multicast entry keeps its type, and the flushed ports are cleared from its port mask.
- R7: An overlapping multicast entry whose reduced mask holds only bit 0, or no bit at all, is freed: type 0, reduced mask stored, other fields unchanged.
- R8: In full mode, a unicast entry whose port number has its bit set in the flush mask gets type 0 with other fields unchanged. Any other unicast entry, including one whose port number is PORTS or above, is unchanged.
- R9: In multicast-only mode (mode bit 1), unicast entries and multicast entries with an all-ones MAC address are unchanged.
- R10: A command presented while busy is ignored. It neither alters the running sweep nor starts another.
- R11: In full mode, the all-ones multicast entry is trimmed like any other multicast entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Flush command strobe |
| cmd_ports | input | PORTS | Ports to flush |
| cmd_mc_only | input | 1 | 1 = multicast-only sweep, 0 = full sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | IDX_W | Table read index |
| tbl_rd_data | input | ENTRY_W | Entry returned one cycle after the read strobe |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_addr | output | IDX_W | Table write index |
| tbl_wr_data | output | ENTRY_W | Entry written back |

## Verification
The bench builds the block with PORTS=3 and DEPTH=6. A non-power-of-two depth checks that the sweep stops at index 5 and does not run to the end of the 3-bit index range. With three ports, the 2-bit port number field can hold the value 3, which no flush mask bit covers, so the out-of-range unicast case can be tested. A small mask width also lets a handful of entries cover the trim, host-only free, empty-mask free and no-overlap cases in each mode.

// File: rtl/ptfl_pkg.sv
package ptfl_pkg;

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_VLAN  = 2'd2,
        KIND_VADDR = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } sweep_state_e;

    localparam int VID_W = 12;
    localparam int MAC_W = 48;

endpackage

// File: rtl/ptfl_rule.sv
module ptfl_rule
    import ptfl_pkg::*;
#(
    parameter int PORTS   = 3,
    parameter int PN_W    = 2,
    parameter int ENTRY_W = 68
) (
    input  logic [ENTRY_W-1:0] ent_in,
    input  logic [PORTS-1:0]   flush_ports,
    input  logic               mc_only,
    output logic [ENTRY_W-1:0] ent_out,
    output logic               is_addr
);
    localparam int OFS_PMASK = PN_W;
    localparam int OFS_VID   = OFS_PMASK + PORTS;
    localparam int OFS_MAC   = OFS_VID + VID_W;
    localparam int OFS_MC    = OFS_MAC + MAC_W;
    localparam int OFS_KIND  = OFS_MC + 1;

    logic [1:0]       kind;
    logic             mc;
    logic [MAC_W-1:0] mac;
    logic [PORTS-1:0] pmask;
    logic [PORTS-1:0] trimmed;
    logic [PN_W-1:0]  pnum;
    logic             overlap;
    logic             host_left;
    logic             port_hit;

    always_comb begin
        kind      = ent_in[OFS_KIND +: 2];
        mc        = ent_in[OFS_MC];
        mac       = ent_in[OFS_MAC +: MAC_W];
        pmask     = ent_in[OFS_PMASK +: PORTS];
        pnum      = ent_in[0 +: PN_W];
        trimmed   = pmask & ~flush_ports;
        overlap   = |(pmask & flush_ports);
        host_left = ((trimmed >> 1) == '0);
        is_addr   = (kind == KIND_ADDR) || (kind == KIND_VADDR);
        port_hit  = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if (32'(pnum) == p && flush_ports[p]) port_hit = 1'b1;
        end

        ent_out = ent_in;
        if (is_addr) begin
            if (mc) begin
                if (!(mc_only && (&mac)) && overlap) begin
                    ent_out[OFS_PMASK +: PORTS] = trimmed;
                    if (host_left) ent_out[OFS_KIND +: 2] = KIND_FREE;
                end
            end else if (!mc_only && port_hit) begin
                ent_out[OFS_KIND +: 2] = KIND_FREE;
            end
        end
    end

endmodule

// File: rtl/ptfl_seq.sv
module ptfl_seq
    import ptfl_pkg::*;
#(
    parameter int PORTS = 3,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [PORTS-1:0] cmd_ports,
    input  logic             cmd_mc_only,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic             wr_phase,
    output logic [IDX_W-1:0] idx,
    output logic [PORTS-1:0] ports_q,
    output logic             mc_only_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        sweep_state_e     st;
        logic [IDX_W-1:0] idx;
        logic [PORTS-1:0] ports;
        logic             mc_only;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.st      = ST_READ;
                    s_d.idx     = '0;
                    s_d.ports   = cmd_ports;
                    s_d.mc_only = cmd_mc_only;
                end
            end
            ST_READ: s_d.st = ST_WRITE;
            ST_WRITE: begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.st  = ST_READ;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, idx: '0, ports: '0, mc_only: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign rd_en     = (s_q.st == ST_READ);
    assign wr_phase  = (s_q.st == ST_WRITE);
    assign idx       = s_q.idx;
    assign ports_q   = s_q.ports;
    assign mc_only_q = s_q.mc_only;

    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |-> $past(rd_en) && idx == $past(idx));

    a_r2_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    a_r10_command_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(ports_q) && $stable(mc_only_q));

    a_r3_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && idx != '0 |-> idx == $past(idx, 2) + 1'b1);

endmodule

// File: rtl/ptfl_sweeper.sv
module ptfl_sweeper
    import ptfl_pkg::*;
#(
    parameter int PORTS   = 3,
    parameter int DEPTH   = 8,
    parameter int PN_W    = (PORTS > 1) ? $clog2(PORTS) : 1,
    parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int ENTRY_W = PN_W + PORTS + VID_W + MAC_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [PORTS-1:0]   cmd_ports,
    input  logic               cmd_mc_only,
    output logic               busy,
    output logic               done,
    output logic               tbl_rd_en,
    output logic [IDX_W-1:0]   tbl_rd_addr,
    input  logic [ENTRY_W-1:0] tbl_rd_data,
    output logic               tbl_wr_en,
    output logic [IDX_W-1:0]   tbl_wr_addr,
    output logic [ENTRY_W-1:0] tbl_wr_data
);
    localparam int OFS_PMASK = PN_W;
    localparam int OFS_VID   = OFS_PMASK + PORTS;
    localparam int OFS_MAC   = OFS_VID + VID_W;
    localparam int OFS_MC    = OFS_MAC + MAC_W;
    localparam int OFS_KIND  = OFS_MC + 1;

    logic             wr_phase;
    logic [IDX_W-1:0] idx;
    logic [PORTS-1:0] ports_q;
    logic             mc_only_q;
    logic             is_addr;

    ptfl_seq #(.PORTS(PORTS), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ports  (cmd_ports),
        .cmd_mc_only(cmd_mc_only),
        .busy       (busy),
        .done       (done),
        .rd_en      (tbl_rd_en),
        .wr_phase   (wr_phase),
        .idx        (idx),
        .ports_q    (ports_q),
        .mc_only_q  (mc_only_q)
    );

    ptfl_rule #(.PORTS(PORTS), .PN_W(PN_W), .ENTRY_W(ENTRY_W)) u_rule (
        .ent_in     (tbl_rd_data),
        .flush_ports(ports_q),
        .mc_only    (mc_only_q),
        .ent_out    (tbl_wr_data),
        .is_addr    (is_addr)
    );

    assign tbl_rd_addr = idx;
    assign tbl_wr_addr = idx;
    assign tbl_wr_en   = wr_phase && is_addr;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> !busy && !done && !tbl_rd_en && !tbl_wr_en);

    a_r4_only_address_written: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> tbl_rd_data[OFS_KIND +: 2] == KIND_ADDR
                   || tbl_rd_data[OFS_KIND +: 2] == KIND_VADDR);

    a_r6_mask_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en && tbl_rd_data[OFS_MC] |->
            (tbl_wr_data[OFS_PMASK +: PORTS] & ~tbl_rd_data[OFS_PMASK +: PORTS]) == '0);

    a_r7_no_host_only_survivor: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en && tbl_rd_data[OFS_MC]
        && tbl_wr_data[OFS_KIND +: 2] != KIND_FREE
        && tbl_wr_data[OFS_PMASK +: PORTS] != tbl_rd_data[OFS_PMASK +: PORTS]
        |-> (tbl_wr_data[OFS_PMASK +: PORTS] >> 1) != '0);

    a_r5_address_kept: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> tbl_wr_data[OFS_MAC +: MAC_W] == tbl_rd_data[OFS_MAC +: MAC_W]);

endmodule

// File: tb/test_ptfl_sweeper.sv
module test_ptfl_sweeper;
    localparam int PORTS = 3;
    localparam int DEPTH = 6;
    localparam int IDX_W = 3;
    localparam int EW    = 68;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [PORTS-1:0] cmd_ports = '0;
    logic cmd_mc_only = 1'b0;
    logic busy, done, tbl_rd_en, tbl_wr_en;
    logic [IDX_W-1:0] tbl_rd_addr, tbl_wr_addr;
    logic [EW-1:0] tbl_rd_data, tbl_wr_data;

    logic [EW-1:0] mem [DEPTH];
    int wcnt [DEPTH];
    int rlog [16];
    int rn;
    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ptfl_sweeper #(.PORTS(PORTS), .DEPTH(DEPTH)) i_ptfl_sweeper (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ports(cmd_ports),
        .cmd_mc_only(cmd_mc_only), .busy(busy), .done(done),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data)
    );

    always @(posedge clk) begin
        if (tbl_rd_en) begin
            tbl_rd_data <= mem[tbl_rd_addr];
            if (rn < 16) rlog[rn] = int'(tbl_rd_addr);
            rn = rn + 1;
        end
        if (tbl_wr_en) begin
            mem[tbl_wr_addr] <= tbl_wr_data;
            wcnt[tbl_wr_addr] = wcnt[tbl_wr_addr] + 1;
        end
    end

    function automatic logic [EW-1:0] mk(input logic [1:0] kind, input logic mc,
        input logic [47:0] mac, input logic [11:0] vid, input logic [2:0] pm,
        input logic [1:0] pn);
        return {kind, mc, mac, vid, pm, pn};
    endfunction

    function automatic logic [EW-1:0] freed(input logic [EW-1:0] e);
        logic [EW-1:0] r = e;
        r[EW-1 -: 2] = 2'd0;
        return r;
    endfunction

    task automatic chk_int(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_ent(input int i, input logic [EW-1:0] exp, input string tag);
        n_tests++;
        if (mem[i] !== exp) begin
            n_fail++;
            $display("FAIL %s idx %0d: actual %h expected %h", tag, i, mem[i], exp);
        end
    endtask

    task automatic clear_logs();
        rn = 0;
        for (int i = 0; i < DEPTH; i++) wcnt[i] = 0;
    endtask

    // issue one command, observe 40 cycles; second command optional while busy
    task automatic run_flush(input logic [2:0] pm, input logic mode, input bit poke,
        output int busy_cyc, output int done_cnt);
        busy_cyc = 0;
        done_cnt = 0;
        clear_logs();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_ports = pm; cmd_mc_only = mode;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (poke && k == 3) begin
                cmd_valid = 1'b1; cmd_ports = 3'b010; cmd_mc_only = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            if (busy) busy_cyc++;
            if (done) done_cnt++;
        end
    endtask

    task automatic chk_order(input string tag);
        chk_int(rn, DEPTH, {tag, " read count"});
        for (int i = 0; i < DEPTH; i++) chk_int(rlog[i], i, {tag, " read order"});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_int(int'(busy), 0, "R1 busy");
        chk_int(int'(done), 0, "R1 done");
        chk_int(int'(tbl_rd_en), 0, "R1 rd_en");
        chk_int(int'(tbl_wr_en), 0, "R1 wr_en");
    endtask

    task automatic t_full();
        logic [EW-1:0] e [DEPTH];
        int bc, dc;
        e[0] = mk(2'd0, 1'b0, 48'h0000_1111_2222, 12'd0, 3'b000, 2'd1);
        e[1] = mk(2'd2, 1'b0, 48'h0, 12'd5, 3'b111, 2'd1);
        e[2] = mk(2'd1, 1'b0, 48'h0200_0000_0001, 12'd0, 3'b000, 2'd1);
        e[3] = mk(2'd3, 1'b0, 48'h0200_0000_0002, 12'd7, 3'b000, 2'd2);
        e[4] = mk(2'd1, 1'b1, 48'h0100_5E00_0001, 12'd0, 3'b110, 2'd0);
        e[5] = mk(2'd3, 1'b1, 48'h0100_5E00_0002, 12'd9, 3'b011, 2'd0);
        for (int i = 0; i < DEPTH; i++) mem[i] = e[i];
        run_flush(3'b010, 1'b0, 1'b0, bc, dc);
        chk_int(bc, 2 * DEPTH, "R2 busy length");
        chk_int(dc, 1, "R2 done pulses");
        chk_order("R3 full");
        chk_int(wcnt[0] + wcnt[1], 0, "R4 skipped entries written");
        chk_int(wcnt[2] + wcnt[3] + wcnt[4] + wcnt[5], 4, "R3 address entries written");
        chk_ent(0, e[0], "R4 free unchanged");
        chk_ent(1, e[1], "R4 vlan unchanged");
        chk_ent(2, freed(e[2]), "R8 unicast on flushed port freed");
        chk_ent(3, e[3], "R8 unicast other port kept");
        chk_ent(4, mk(2'd1, 1'b1, 48'h0100_5E00_0001, 12'd0, 3'b100, 2'd0), "R6 trimmed");
        chk_ent(5, mk(2'd0, 1'b1, 48'h0100_5E00_0002, 12'd9, 3'b001, 2'd0), "R7 host only freed");
    endtask

    task automatic t_mc_only();
        logic [EW-1:0] e [DEPTH];
        int bc, dc;
        e[0] = mk(2'd1, 1'b0, 48'h0200_0000_0010, 12'd0, 3'b000, 2'd1);
        e[1] = mk(2'd1, 1'b1, BCAST, 12'd0, 3'b111, 2'd0);
        e[2] = mk(2'd1, 1'b1, 48'h0100_5E00_0003, 12'd0, 3'b001, 2'd0);
        e[3] = mk(2'd3, 1'b1, 48'h0100_5E00_0004, 12'd3, 3'b110, 2'd0);
        e[4] = mk(2'd1, 1'b1, 48'h0100_5E00_0005, 12'd0, 3'b111, 2'd0);
        e[5] = mk(2'd3, 1'b0, 48'h0200_0000_0011, 12'd4, 3'b000, 2'd2);
        for (int i = 0; i < DEPTH; i++) mem[i] = e[i];
        run_flush(3'b110, 1'b1, 1'b0, bc, dc);
        chk_order("R3 mc-only");
        chk_ent(0, e[0], "R9 unicast untouched");
        chk_ent(1, e[1], "R9 broadcast untouched");
        chk_ent(2, e[2], "R5 no overlap unchanged");
        chk_ent(3, mk(2'd0, 1'b1, 48'h0100_5E00_0004, 12'd3, 3'b000, 2'd0), "R7 empty mask freed");
        chk_ent(4, mk(2'd0, 1'b1, 48'h0100_5E00_0005, 12'd0, 3'b001, 2'd0), "R7 host only freed");
        chk_ent(5, e[5], "R9 vlan unicast untouched");
    endtask

    task automatic t_full_bcast();
        logic [EW-1:0] e [DEPTH];
        int bc, dc;
        e[0] = mk(2'd1, 1'b1, BCAST, 12'd0, 3'b111, 2'd0);
        e[1] = mk(2'd1, 1'b0, 48'h0200_0000_0020, 12'd0, 3'b000, 2'd3);
        e[2] = mk(2'd3, 1'b0, 48'h0200_0000_0021, 12'd2, 3'b000, 2'd2);
        e[3] = mk(2'd1, 1'b1, 48'h0100_5E00_0006, 12'd0, 3'b011, 2'd0);
        e[4] = mk(2'd0, 1'b1, 48'h0100_5E00_0007, 12'd0, 3'b100, 2'd0);
        e[5] = mk(2'd2, 1'b0, 48'h0, 12'd8, 3'b100, 2'd2);
        for (int i = 0; i < DEPTH; i++) mem[i] = e[i];
        run_flush(3'b100, 1'b0, 1'b0, bc, dc);
        chk_ent(0, mk(2'd1, 1'b1, BCAST, 12'd0, 3'b011, 2'd0), "R11 broadcast trimmed");
        chk_ent(1, e[1], "R8 out-of-range port kept");
        chk_ent(2, freed(e[2]), "R8 port 2 freed");
        chk_ent(3, e[3], "R5 no overlap unchanged");
        chk_int(wcnt[4] + wcnt[5], 0, "R4 free and vlan not written");
        chk_int(dc, 1, "R2 done pulses");
    endtask

    task automatic t_busy_ignore();
        logic [EW-1:0] e [DEPTH];
        int bc, dc;
        e[0] = mk(2'd1, 1'b0, 48'h0200_0000_0030, 12'd0, 3'b000, 2'd0);
        e[1] = mk(2'd1, 1'b0, 48'h0200_0000_0031, 12'd0, 3'b000, 2'd1);
        e[2] = mk(2'd1, 1'b1, 48'h0100_5E00_0008, 12'd0, 3'b110, 2'd0);
        e[3] = mk(2'd0, 1'b0, 48'h0, 12'd0, 3'b000, 2'd0);
        e[4] = mk(2'd0, 1'b0, 48'h0, 12'd0, 3'b000, 2'd0);
        e[5] = mk(2'd1, 1'b0, 48'h0200_0000_0032, 12'd0, 3'b000, 2'd0);
        for (int i = 0; i < DEPTH; i++) mem[i] = e[i];
        run_flush(3'b001, 1'b0, 1'b1, bc, dc);
        chk_int(bc, 2 * DEPTH, "R10 busy length with late command");
        chk_int(dc, 1, "R10 single done");
        chk_ent(0, freed(e[0]), "R10 first command applied");
        chk_ent(1, e[1], "R10 late command mask ignored");
        chk_ent(2, e[2], "R10 late command no trim");
        chk_ent(5, freed(e[5]), "R10 first command to end");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rn = 0;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0;
            wcnt[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_mc_only();
        t_full_bcast();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule